// File: doc/BRIEF.md
# Capacitance Conversion Result Register File with Read Lock

This block keeps the most recent conversion result of each capacitance channel in a 16-bit register. It offers those registers to a serial-bus slave front end as a byte-addressed, read-only space. The front end signals three things: the start of a read with its byte address, each byte that is consumed, and the bus stop condition. The block answers with the byte at the current address pointer. The pointer then steps forward, so both bytes of a result can be fetched in one transaction.

A converter raises a per-channel done strobe together with a 12-bit code. The register takes the code in its upper twelve bits, and its lowest four bits are zero. While a read transaction is open, every channel register is frozen. A result that completes in that window is thrown away, not queued. The window opens with the read start and stays open up to and including the cycle of the stop condition. Because of this, the two bytes read in one transaction always belong to the same conversion.

The block stores codes as they arrive. Nominal codes run from 0x300 (zero scale, register 0x3000) through 0x800 (mid scale, 0x8000) to 0xCFF (full scale, 0xCFF0). The marker codes 0x000 (underrange) and 0xFFF (overrange, 0xFFF0) are stored and read back like any other code.

Top module: `cap_result_regs`

## Requirements
- R1: After a synchronous active-low reset, every channel register reads 0x0000, the address pointer is 0x00, and no read transaction is open, so the next conversion is loaded.
- R2: Byte address map: 0x01 returns channel 1 bits [15:8] and 0x02 returns channel 1 bits [7:0]; 0x03 and 0x04 do the same for channel 2. `rd_byte` follows the current pointer combinationally.
- R3: A conversion strobe with no open read loads the register with {code, 4'h0}, visible from the next cycle. The low nibble of every low byte reads 0.
- R4: A conversion strobe in a cycle where `rd_start` is high, a transaction is open, or `bus_stop` is high is discarded and never applied later.
- R5: `bus_stop` closes the transaction, so a strobe in the following cycle loads. If `rd_start` and `bus_stop` are high in the same cycle, the start wins and the transaction stays open.
- R6: `rd_start` loads the pointer from `rd_addr`. `rd_next` increments it modulo 256. When both are high, `rd_start` wins.
- R7: Any pointer value outside 0x01..0x04 returns 0x00.
- R8: Every 12-bit code, including 0x000 (underrange), 0x300, 0x800, 0xCFF and 0xFFF (overrange), is stored and read back unchanged.
- R9: The high and low bytes read in one transaction come from the same conversion, even if a conversion completes between the two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 2 | Per-channel conversion complete strobe (bit 0 = channel 1) |
| conv_code | input | 24 | Per-channel 12-bit codes, channel 1 in bits [11:0] |
| rd_start | input | 1 | Read start: loads pointer, opens transaction |
| rd_addr | input | 8 | Byte address taken at read start |
| rd_next | input | 1 | Byte consumed: advance pointer |
| bus_stop | input | 1 | Bus stop condition: closes transaction |
| rd_byte | output | 8 | Byte at the current pointer |
| rd_ptr | output | 8 | Current address pointer |

## Verification
All state changes happen on one clock edge. A conversion strobe, a pointer load or increment, and the close at `bus_stop` all take effect one cycle after the stimulus. `rd_byte` is combinational from the pointer, so it carries the addressed byte in the same cycle the pointer shows the new address. The bench drives every input just after a falling edge. It samples outputs at the next falling edge, half a period after the rising edge that committed the change, so each check sees exactly one edge's effect. Lock behaviour is tested by placing strobes in the start cycle, between the two bytes, and in the stop cycle, then reading the register back in a fresh transaction.

// File: rtl/cap_result_pkg.sv
// Shared constants and helpers for the conversion result register file.
// Assumes two 8-bit bytes per register and that the first mapped byte
// address is fixed by the bus-side address map.
package cap_result_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_W     = 2 * BYTE_W;
    localparam int MAP_BASE  = 1;

    // Byte address of the high byte of channel c.
    function automatic int hi_addr(input int c);
        return MAP_BASE + 2 * c;
    endfunction
endpackage

// File: rtl/crr_read_window.sv
// Tracks whether a bus read transaction is open and produces the update lock.
// Assumes rd_start and bus_stop are single-cycle pulses from the bus front end.
module crr_read_window (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  logic bus_stop,
    output logic lock
);
    logic open_q;

    // Open on read start (priority), close on stop condition.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (rd_start) open_q <= 1'b1;
        else if (bus_stop) open_q <= 1'b0;
    end

    // Lock covers the start cycle and every cycle up to and including stop.
    always_comb lock = open_q | rd_start;

    AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !rd_start) |=> !open_q); // R5
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> open_q); // R5
endmodule

// File: rtl/crr_addr_ptr.sv
// Byte address pointer: loaded at read start, auto-incremented per byte.
// Assumes rd_start takes priority over rd_next in the same cycle.
module crr_addr_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_next,
    output logic [ADDR_W-1:0] ptr
);
    // Load, increment (wrapping) or hold the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (rd_start) ptr <= rd_addr;
        else if (rd_next)  ptr <= ptr + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_next && !rd_start) |=> ptr == $past(ptr) + 1'b1); // R6
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> ptr == $past(rd_addr)); // R6
endmodule

// File: rtl/crr_channel_reg.sv
// One channel's 16-bit result register. The code fills the upper bits and
// the padding bits stay zero. Updates are dropped while locked.
// Assumes done is a single-cycle strobe with code valid in that cycle.
module crr_channel_reg #(
    parameter int CODE_W = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              done,
    input  logic [CODE_W-1:0] code,
    output logic [REG_W-1:0]  value
);
    localparam int PAD_W = REG_W - CODE_W;

    // Capture a finished conversion unless a read holds the register.
    always_ff @(posedge clk) begin
        if (!rst_n)              value <= '0;
        else if (done && !lock)  value <= {code, {PAD_W{1'b0}}};
    end

    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lock) |=> value[REG_W-1:PAD_W] == $past(code)); // R3
    AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(value)); // R4
endmodule

// File: rtl/crr_byte_mux.sv
// Selects the byte addressed by the pointer. Unmapped addresses give zero.
// Assumes registers are packed channel 0 first in the flat input.
module crr_byte_mux
    import cap_result_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    ptr,
    input  logic [NCH*REG_W-1:0] regs,
    output logic [BYTE_W-1:0]    rd_byte
);
    localparam int LAST_ADDR = hi_addr(NCH - 1) + 1;

    // Decode the pointer against each channel's high and low byte address.
    always_comb begin
        rd_byte = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ptr == ADDR_W'(hi_addr(c)))
                rd_byte = regs[c*REG_W+BYTE_W +: BYTE_W];
            if (ptr == ADDR_W'(hi_addr(c) + 1))
                rd_byte = regs[c*REG_W +: BYTE_W];
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr < ADDR_W'(MAP_BASE) || ptr > ADDR_W'(LAST_ADDR)) |-> rd_byte == '0); // R7
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == ADDR_W'(MAP_BASE + 1)) |-> rd_byte[3:0] == 4'h0); // R3
endmodule

// File: rtl/cap_result_regs.sv
// Top of the conversion result register file. One register per channel,
// a shared read lock, an auto-incrementing pointer and a byte read mux.
// Assumes the bus front end gives single-cycle start, next and stop pulses.
module cap_result_regs
    import cap_result_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        conv_done,
    input  logic [NCH*CODE_W-1:0] conv_code,
    input  logic                  rd_start,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_next,
    input  logic                  bus_stop,
    output logic [BYTE_W-1:0]     rd_byte,
    output logic [ADDR_W-1:0]     rd_ptr
);
    logic                 lock;
    logic [NCH*REG_W-1:0] regs;

    crr_read_window u_win (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
        .bus_stop(bus_stop), .lock(lock)
    );

    crr_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
        .rd_addr(rd_addr), .rd_next(rd_next), .ptr(rd_ptr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        crr_channel_reg #(.CODE_W(CODE_W), .REG_W(REG_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .lock(lock),
            .done(conv_done[c]),
            .code(conv_code[c*CODE_W +: CODE_W]),
            .value(regs[c*REG_W +: REG_W])
        );
    end

    crr_byte_mux #(.NCH(NCH), .ADDR_W(ADDR_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .ptr(rd_ptr), .regs(regs), .rd_byte(rd_byte)
    );

    AST_RESET_PTR: assert property (@(posedge clk)
        !rst_n |=> rd_ptr == '0); // R1
endmodule

// File: tb/tb_cap_result_regs.sv
module tb_cap_result_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  conv_done = 0;
    logic [23:0] conv_code = 0;
    logic        rd_start = 0;
    logic [7:0]  rd_addr = 0;
    logic        rd_next = 0;
    logic        bus_stop = 0;
    logic [7:0]  rd_byte;
    logic [7:0]  rd_ptr;

    int checks = 0;
    int errors = 0;
    logic [11:0] model [2];

    cap_result_regs dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_code(conv_code),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_next(rd_next),
        .bus_stop(bus_stop), .rd_byte(rd_byte), .rd_ptr(rd_ptr)
    );

    always #5 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected byte at an address from the model registers.
    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        logic [15:0] r;
        if (a >= 8'd1 && a <= 8'd4) begin
            r = {model[(a - 1) / 2], 4'h0};
            return (a[0]) ? r[15:8] : r[7:0];
        end
        return 8'h00;
    endfunction

    task automatic conv(input int ch, input logic [11:0] code);
        conv_done[ch] = 1'b1;
        conv_code[ch*12 +: 12] = code;
        cyc();
        conv_done = '0;
    endtask

    task automatic read_reg(input int ch, output logic [15:0] val);
        logic [7:0] hi;
        rd_start = 1; rd_addr = 8'(1 + 2 * ch);
        cyc();
        rd_start = 0; hi = rd_byte; rd_next = 1;
        cyc();
        rd_next = 0; val = {hi, rd_byte}; bus_stop = 1;
        cyc();
        bus_stop = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : stim
        logic [15:0] v;
        logic [11:0] codes [5];
        codes[0] = 12'h000; codes[1] = 12'h300; codes[2] = 12'h800;
        codes[3] = 12'hCFF; codes[4] = 12'hFFF;
        model[0] = 0; model[1] = 0;
        repeat (3) cyc();
        rst_n = 1;
        chk("R1 ptr", {8'h0, rd_ptr}, 16'h0);
        for (int c = 0; c < 2; c++) begin
            read_reg(c, v); chk("R1 reg", v, 16'h0000);
        end
        // R1: no lock left after reset, first conversion loads
        conv(0, 12'h123); model[0] = 12'h123;
        read_reg(0, v); chk("R1 load after reset", v, 16'h1230);

        // R8 / R3 / R2: sweep codes on both channels
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 5 + 43; i++) begin
                logic [11:0] k;
                k = (i < 5) ? codes[i] : 12'((i - 5) * 97 + c * 13);
                conv(c, k); model[c] = k;
                read_reg(c, v);
                chk("R8 R3 stored code", v, {k, 4'h0});
                chk("R3 low nibble", {12'h0, v[3:0]}, 16'h0);
            end
            read_reg(1 - c, v);
            chk("R2 other channel untouched", v, {model[1 - c], 4'h0});
        end

        // R7 / R2: sweep every address
        conv(0, 12'hA5C); model[0] = 12'hA5C;
        conv(1, 12'h3E7); model[1] = 12'h3E7;
        for (int a = 0; a < 256; a++) begin
            rd_start = 1; rd_addr = 8'(a);
            cyc();
            rd_start = 0;
            chk("R7 R2 addressed byte", {8'h0, rd_byte}, {8'h0, exp_byte(8'(a))});
            bus_stop = 1; cyc(); bus_stop = 0;
        end

        // R4 / R9: strobes in start cycle, between bytes, and in stop cycle
        rd_start = 1; rd_addr = 8'd1;
        conv_done[0] = 1; conv_code[11:0] = 12'h111;
        cyc();
        rd_start = 0; conv_done = 0;
        v[15:8] = rd_byte;
        chk("R4 start-cycle drop hi", {8'h0, v[15:8]}, {8'h0, exp_byte(8'd1)});
        conv_done[0] = 1; conv_code[11:0] = 12'h222; rd_next = 1;
        cyc();
        conv_done = 0; rd_next = 0;
        chk("R9 low byte same conversion", {8'h0, rd_byte}, {8'h0, exp_byte(8'd2)});
        bus_stop = 1; conv_done = 2'b11; conv_code = {12'h333, 12'h333};
        cyc();
        bus_stop = 0; conv_done = 0;
        read_reg(0, v); chk("R4 dropped, not deferred ch1", v, {model[0], 4'h0});
        read_reg(1, v); chk("R4 dropped, not deferred ch2", v, {model[1], 4'h0});

        // R5: strobe right after stop loads
        conv(1, 12'h456); model[1] = 12'h456;
        read_reg(1, v); chk("R5 load after stop", v, 16'h4560);

        // R5: start and stop together keeps transaction open
        rd_start = 1; bus_stop = 1; rd_addr = 8'd3;
        cyc();
        rd_start = 0; bus_stop = 0;
        conv(1, 12'h789);
        bus_stop = 1; cyc(); bus_stop = 0;
        read_reg(1, v); chk("R5 start beats stop", v, 16'h4560);

        // R6: wrap and priority
        rd_start = 1; rd_addr = 8'hFF; cyc(); rd_start = 0;
        rd_next = 1; cyc(); rd_next = 0;
        chk("R6 wrap", {8'h0, rd_ptr}, 16'h0000);
        chk("R7 wrapped address zero", {8'h0, rd_byte}, 16'h0000);
        rd_start = 1; rd_next = 1; rd_addr = 8'd3; cyc();
        rd_start = 0; rd_next = 0;
        chk("R6 start beats next", {8'h0, rd_ptr}, 16'h0003);
        rd_next = 1; cyc(); rd_next = 0;
        chk("R6 increment", {8'h0, rd_ptr}, 16'h0004);
        bus_stop = 1; cyc(); bus_stop = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule